// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

A four-bit counter with two count strobes, one that steps the value up and one that steps it down. A parameter fixes the counting range at construction: binary wraps at 16 and decade (BCD) wraps at 10. An active-high clear and an active-low preset load set the value directly. The carry and borrow outputs are active low, so several stages can be chained by connecting one stage's carry and borrow to the up and down strobes of the next stage.

The count strobes are treated as asynchronous. Each strobe passes through a two-flop synchronizer clocked by the system clock, and a rising edge is found by comparing the synchronized level with its value one cycle earlier. A step up needs the down strobe to be high, and a step down needs the up strobe to be high. Clear and load are sampled on the system clock and take priority over counting, in that order. Decade stages leave any illegal value (10 to 15) on their next step.

Top module: `updown_counter`

## Requirements
- R1: While `clear` is high at a clock edge, `count` becomes 0 on that edge, whatever `load_n`, `preset` and the strobes are doing.
- R2: While `clear` is low and `load_n` is low at a clock edge, `count` takes `preset` on that edge, and strobe edges are ignored. A decade stage keeps a loaded value of 10 to 15 unchanged.
- R3: A rising edge on `up_clk` while `dn_clk` is high adds one to `count`. The new value appears on the third system clock edge after the strobe changes.
- R4: A rising edge on `dn_clk` while `up_clk` is high subtracts one from `count`, with the same latency as R3.
- R5: A rising edge on one strobe while the other strobe is low leaves `count` unchanged.
- R6: If both strobes rise in the same cycle after synchronization, `count` holds.
- R7: `carry_n` is low exactly while `count` equals the top value (9 in decade mode, 15 in binary mode) and the synchronized `up_clk` is low. Otherwise it is high.
- R8: `borrow_n` is low exactly while `count` is 0 and the synchronized `dn_clk` is low. Otherwise it is high.
- R9: Counting up from the top value gives 0, and counting down from 0 gives the top value. For example, decade mode gives 7,8,9,0,1,2 and binary mode gives 13,14,15,0,1,2.
- R10: In decade mode, one up step from any value 10 to 15 gives 0, and one down step from any of those values gives 9.
- R11: Two decade stages chained through carry_n→up_clk and borrow_n→dn_clk count as a two-digit decimal number, up and down across digit boundaries.
- R12: After reset, `count` is 0 and `carry_n` and `borrow_n` are high. Releasing reset while both strobes are high causes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_clk | input | 1 | Up-count strobe, counts on its rising edge |
| dn_clk | input | 1 | Down-count strobe, counts on its rising edge |
| load_n | input | 1 | Active-low preset load |
| clear | input | 1 | Active-high clear, highest priority |
| preset | input | 4 | Value taken during a load |
| count | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal count going up |
| borrow_n | output | 1 | Active-low terminal count going down |

## Verification
Two pairs of events can land in the same cycle, and each pair is forced on purpose. The first pair is the two strobes: the bench drives both low together and releases them together, so both rising edges reach the counter in one cycle, and it checks that the count holds. The second pair is a control signal against a strobe: a full up pulse is driven while `clear` is held, and `clear` is raised together with `load_n` low. The count must show the higher-priority action, 0 in both cases. Every value 0 to 15 is also loaded and then stepped once in each direction on a binary stage and on a decade stage, and the results are checked against wrap arithmetic computed in the bench.

// File: rtl/updn_pkg.sv
package updn_pkg;
    localparam int CW = 4;
    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t cnt;
    } ctr_state_t;

    function automatic cnt_t top_value(input bit decade);
        return decade ? cnt_t'(9) : cnt_t'(2**CW - 1);
    endfunction
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sr;
        logic              prev;
    } sync_state_t;

    sync_state_t st_d, st_q;
    logic [STAGES-1:0] shift_d;

    assign shift_d[0] = async_in;
    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        assign shift_d[i] = st_q.sr[i-1];
    end

    always_comb begin
        st_d      = st_q;
        st_d.sr   = shift_d;
        st_d.prev = st_q.sr[STAGES-1];
    end

    // Idle level of a strobe is high, so reset to 1 to avoid a false edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.sr[STAGES-1];
    assign rise  = st_q.sr[STAGES-1] & ~st_q.prev;

    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R3
endmodule

// File: rtl/updn_next.sv
module updn_next
    import updn_pkg::*;
#(
    parameter bit DECADE = 1'b0
) (
    input  cnt_t cnt_q,
    input  logic clear,
    input  logic load_n,
    input  cnt_t preset,
    input  logic up_evt,
    input  logic dn_evt,
    output cnt_t cnt_d
);
    localparam cnt_t TOP = top_value(DECADE);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (!load_n) begin
            cnt_d = preset;
        end else if (up_evt) begin
            cnt_d = (cnt_q >= TOP) ? '0 : cnt_q + cnt_t'(1);
        end else if (dn_evt) begin
            cnt_d = (cnt_q == '0 || cnt_q > TOP) ? TOP : cnt_q - cnt_t'(1);
        end
    end
endmodule

// File: rtl/updown_counter.sv
module updown_counter
    import updn_pkg::*;
#(
    parameter bit DECADE      = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_clk,
    input  logic          dn_clk,
    input  logic          load_n,
    input  logic          clear,
    input  logic [CW-1:0] preset,
    output logic [CW-1:0] count,
    output logic          carry_n,
    output logic          borrow_n
);
    localparam cnt_t TOP = top_value(DECADE);

    logic up_lvl, up_rise, dn_lvl, dn_rise;
    logic up_evt, dn_evt;
    ctr_state_t st_d, st_q;
    cnt_t cnt_nxt;

    updn_sync #(.STAGES(SYNC_STAGES)) u_sync_up (
        .clk(clk), .rst_n(rst_n), .async_in(up_clk),
        .level(up_lvl), .rise(up_rise)
    );

    updn_sync #(.STAGES(SYNC_STAGES)) u_sync_dn (
        .clk(clk), .rst_n(rst_n), .async_in(dn_clk),
        .level(dn_lvl), .rise(dn_rise)
    );

    // A step needs the opposite strobe high and not rising in the same cycle.
    assign up_evt = up_rise & dn_lvl & ~dn_rise;
    assign dn_evt = dn_rise & up_lvl & ~up_rise;

    updn_next #(.DECADE(DECADE)) u_next (
        .cnt_q(st_q.cnt), .clear(clear), .load_n(load_n), .preset(preset),
        .up_evt(up_evt), .dn_evt(dn_evt), .cnt_d(cnt_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count    = st_q.cnt;
    assign carry_n  = ~((st_q.cnt == TOP) & ~up_lvl);
    assign borrow_n = ~((st_q.cnt == '0) & ~dn_lvl);

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R1
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !load_n) |=> (count == $past(preset))); // R2
    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt && load_n && !clear && st_q.cnt < TOP)
        |=> (count == $past(st_q.cnt) + cnt_t'(1))); // R3
    AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_evt && load_n && !clear && st_q.cnt != '0 && st_q.cnt <= TOP)
        |=> (count == $past(st_q.cnt) - cnt_t'(1))); // R4
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rise && dn_rise && load_n && !clear) |=> $stable(count)); // R6
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt && load_n && !clear && st_q.cnt >= TOP) |=> (count == '0)); // R10
    AST_DN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_evt && load_n && !clear && (st_q.cnt == '0 || st_q.cnt > TOP))
        |=> (count == TOP)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_rise && !dn_rise && load_n && !clear) |=> $stable(count)); // R5
endmodule

// File: tb/updown_counter_bench.sv
`timescale 1ns/1ps
module updown_counter_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic up_clk = 1'b1, dn_clk = 1'b1, load_n = 1'b1, clear = 1'b0;
    logic [3:0] preset = 4'd0;
    logic [3:0] cnt_dec, cnt_bin;
    logic carry_dec, borrow_dec, carry_bin, borrow_bin;

    logic c_up = 1'b1, c_dn = 1'b1;
    logic [3:0] lo_cnt, hi_cnt;
    logic lo_carry, lo_borrow, hi_carry, hi_borrow;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_dec = 0;
    int exp_bin = 0;
    int casc    = 0;

    updown_counter #(.DECADE(1'b1)) u_updown_counter (
        .clk(clk), .rst_n(rst_n), .up_clk(up_clk), .dn_clk(dn_clk),
        .load_n(load_n), .clear(clear), .preset(preset),
        .count(cnt_dec), .carry_n(carry_dec), .borrow_n(borrow_dec)
    );

    updown_counter #(.DECADE(1'b0)) u_bin (
        .clk(clk), .rst_n(rst_n), .up_clk(up_clk), .dn_clk(dn_clk),
        .load_n(load_n), .clear(clear), .preset(preset),
        .count(cnt_bin), .carry_n(carry_bin), .borrow_n(borrow_bin)
    );

    updown_counter #(.DECADE(1'b1)) u_lo (
        .clk(clk), .rst_n(rst_n), .up_clk(c_up), .dn_clk(c_dn),
        .load_n(1'b1), .clear(clear), .preset(4'd0),
        .count(lo_cnt), .carry_n(lo_carry), .borrow_n(lo_borrow)
    );

    updown_counter #(.DECADE(1'b1)) u_hi (
        .clk(clk), .rst_n(rst_n), .up_clk(lo_carry), .dn_clk(lo_borrow),
        .load_n(1'b1), .clear(clear), .preset(4'd0),
        .count(hi_cnt), .carry_n(hi_carry), .borrow_n(hi_borrow)
    );

    function automatic int step_up(input int v, input int m);
        return (v >= m - 1) ? 0 : v + 1;
    endfunction

    function automatic int step_dn(input int v, input int m);
        return (v == 0 || v >= m) ? m - 1 : v - 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_counts(input string req);
        chk({req, " dec"}, int'(cnt_dec), exp_dec);
        chk({req, " bin"}, int'(cnt_bin), exp_bin);
    endtask

    task automatic do_load(input int v);
        preset = 4'(v);
        load_n = 1'b0;
        wait_n(2);
        load_n = 1'b1;
        wait_n(1);
        exp_dec = v;
        exp_bin = v;
        check_counts("R2 load");
    endtask

    task automatic pulse_up();
        up_clk = 1'b0;
        wait_n(4);
        chk("R7 carry dec", int'(carry_dec), (exp_dec == 9) ? 0 : 1);
        chk("R7 carry bin", int'(carry_bin), (exp_bin == 15) ? 0 : 1);
        up_clk = 1'b1;
        wait_n(4);
        if (dn_clk) begin
            exp_dec = step_up(exp_dec, 10);
            exp_bin = step_up(exp_bin, 16);
        end
        check_counts(dn_clk ? "R3/R9/R10 up" : "R5 up blocked");
        chk("R7 carry idle", int'(carry_dec), 1);
    endtask

    task automatic pulse_dn();
        dn_clk = 1'b0;
        wait_n(4);
        chk("R8 borrow dec", int'(borrow_dec), (exp_dec == 0) ? 0 : 1);
        chk("R8 borrow bin", int'(borrow_bin), (exp_bin == 0) ? 0 : 1);
        dn_clk = 1'b1;
        wait_n(4);
        exp_dec = step_dn(exp_dec, 10);
        exp_bin = step_dn(exp_bin, 16);
        check_counts("R4/R9/R10 down");
        chk("R8 borrow idle", int'(borrow_bin), 1);
    endtask

    task automatic casc_up();
        c_up = 1'b0;
        wait_n(6);
        c_up = 1'b1;
        wait_n(8);
        casc = (casc + 1) % 100;
        chk("R11 cascade lo", int'(lo_cnt), casc % 10);
        chk("R11 cascade hi", int'(hi_cnt), casc / 10);
    endtask

    task automatic casc_dn();
        c_dn = 1'b0;
        wait_n(6);
        c_dn = 1'b1;
        wait_n(8);
        casc = (casc + 99) % 100;
        chk("R11 cascade lo", int'(lo_cnt), casc % 10);
        chk("R11 cascade hi", int'(hi_cnt), casc / 10);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        wait_n(150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(6);
        // R12: reset state, no count on release with strobes high
        check_counts("R12 reset");
        chk("R12 carry", int'(carry_dec), 1);
        chk("R12 borrow", int'(borrow_dec), 1);

        // Sweep every load value, one step each way, in both modes
        for (int v = 0; v < 16; v++) begin
            do_load(v);
            pulse_up();
            do_load(v);
            pulse_dn();
        end

        // R9 sequences: decade from 7, binary from 13
        do_load(7);
        for (int i = 0; i < 12; i++) pulse_up();
        for (int i = 0; i < 12; i++) pulse_dn();
        do_load(13);
        for (int i = 0; i < 6; i++) pulse_up();
        for (int i = 0; i < 6; i++) pulse_dn();

        // R5: up edge while down strobe low is ignored; raising dn then counts down
        do_load(4);
        dn_clk = 1'b0;
        wait_n(4);
        pulse_up();
        dn_clk = 1'b1;
        wait_n(4);
        exp_dec = step_dn(exp_dec, 10);
        exp_bin = step_dn(exp_bin, 16);
        check_counts("R4 down after R5");

        // R6: both strobes rise together
        do_load(6);
        up_clk = 1'b0;
        dn_clk = 1'b0;
        wait_n(4);
        up_clk = 1'b1;
        dn_clk = 1'b1;
        wait_n(5);
        check_counts("R6 both rise hold");

        // R1: clear over load
        preset = 4'd5;
        load_n = 1'b0;
        clear  = 1'b1;
        wait_n(2);
        exp_dec = 0;
        exp_bin = 0;
        check_counts("R1 clear over load");
        clear = 1'b0;
        wait_n(2);
        load_n = 1'b1;
        exp_dec = 5;
        exp_bin = 5;
        check_counts("R2 load after clear");

        // R1: clear held through an up pulse
        clear = 1'b1;
        up_clk = 1'b0;
        wait_n(4);
        up_clk = 1'b1;
        wait_n(4);
        clear = 1'b0;
        wait_n(1);
        exp_dec = 0;
        exp_bin = 0;
        check_counts("R1 clear over count");

        // R2: strobes ignored during load
        preset = 4'd3;
        load_n = 1'b0;
        up_clk = 1'b0;
        wait_n(4);
        up_clk = 1'b1;
        wait_n(4);
        load_n = 1'b1;
        wait_n(1);
        exp_dec = 3;
        exp_bin = 3;
        check_counts("R2 load blocks count");

        // R11: cascade of two decade stages
        clear = 1'b1;
        wait_n(2);
        clear = 1'b0;
        wait_n(1);
        casc = 0;
        for (int i = 0; i < 23; i++) casc_up();
        for (int i = 0; i < 27; i++) casc_dn();

        finish_run();
    end
endmodule